// File: doc/BRIEF.md
# SPI Shift Engine

This block is the serial core of a full-duplex SPI master. Words queued in a transmit FIFO are shifted out on MOSI, most significant bit first. For every word sent, one word is assembled from MISO and placed in a receive FIFO. Software-style configuration inputs set the clock polarity, the clock phase, an internal loopback path and the word length. Five status flags report the FIFO state and whether a transfer is in progress.

The serial clock rate is not generated here. A one-cycle `sclk_tick` strobe from an external divider marks each half period, and every SCLK edge falls on a tick. A single active-low chip select frames a burst of back-to-back words. The engine starts shifting only while `cfg_enable` is high and the transmit FIFO holds data.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, chip select is inactive (high), busy is low, both FIFOs are empty and `status` reads 5'b00011.
- R2: Words go out MSB first. Only the low L bits of a transmit entry are sent, where L = `cfg_len_m1` + 1 (4 to 32). Field values 0, 1 and 2 act as 3, giving 4-bit words.
- R3: While chip select is inactive, SCLK rests at `cfg_cpol`. During a word it returns to that level after every trailing edge.
- R4: With `cfg_cpha` = 0, the first bit is on MOSI before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With `cfg_cpha` = 1, MOSI changes on leading edges and MISO is sampled on trailing edges. Each word has exactly 2L SCLK edges.
- R5: Each transmitted word yields exactly one receive-FIFO entry, in order. The entry is right-aligned and zero-extended above bit L-1.
- R6: With `cfg_loopback` = 1, received bits come from the internal MOSI line, and MISO has no effect.
- R7: Chip select goes low one tick before the first SCLK edge. It stays low across back-to-back words and goes high on the final trailing edge once no further word can start.
- R8: Busy (`status[4]`) is high exactly while chip select is low.
- R9: With `cfg_enable` low, no new word starts. Clearing it during a word lets that word finish, then chip select is released while later words stay queued.
- R10: Status bits are: bit 0 TX FIFO empty, bit 1 TX FIFO not full, bit 2 RX FIFO not empty, bit 3 RX FIFO full, bit 4 busy.
- R11: A word never starts unless its result is sure to fit in the receive FIFO. A push to a full TX FIFO is dropped, and a pop of an empty RX FIFO has no effect.
- R12: SCLK, chip select and the shift state change only in cycles where `sclk_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Allows new words to start |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Phase select: 0 sample on leading edge, 1 sample on trailing edge |
| cfg_loopback | input | 1 | Receive from internal MOSI instead of the MISO pin |
| cfg_len_m1 | input | $clog2(MAX_BITS) | Word length minus one |
| tx_push | input | 1 | Write strobe for the transmit FIFO |
| tx_wdata | input | MAX_BITS | Transmit word |
| rx_pop | input | 1 | Read strobe for the receive FIFO |
| rx_rdata | output | MAX_BITS | Head of the receive FIFO |
| status | output | 5 | FIFO and busy flags |
| sclk_tick | input | 1 | Half-period strobe from the clock divider |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest state to reach from the ports is a queued transmit word held back because the receive FIFO cannot take its result. A second hard case is an enable drop that lands in the middle of a word. The bench fills the receive FIFO by never popping during a loopback burst, pushes one more word and confirms that chip select stays high until a single pop frees space. For the enable case, it waits for chip select to fall, clears the enable a few cycles later and checks that exactly one result appears while the second word stays in the transmit FIFO. A bench-side slave model follows SCLK edges for all four polarity and phase combinations. It drives MISO and captures MOSI, so bit order and edge counts are checked at the pins.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_t;

   // status bit positions
   localparam int STB_TX_EMPTY  = 0;
   localparam int STB_TX_ROOM   = 1;
   localparam int STB_RX_AVAIL  = 2;
   localparam int STB_RX_FULL   = 3;
   localparam int STB_BUSY      = 4;
   localparam int STATUS_W      = 5;

   // shortest supported word, minus one
   localparam int MIN_LEN_M1    = 3;

endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WIDTH-1:0]           wdata,
   input  logic                       pop,
   output logic [WIDTH-1:0]           rdata,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_eng_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign level   = cnt;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   // R11: occupancy never passes the depth, so no entry is overwritten
   a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
   import spi_eng_pkg::*;
#(
   parameter int MAX_BITS = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick,
   input  logic                        enable,
   input  logic                        cfg_cpol,
   input  logic                        cfg_cpha,
   input  logic                        cfg_loopback,
   input  logic [$clog2(MAX_BITS)-1:0] cfg_len_m1,
   input  logic                        tx_valid,
   input  logic [MAX_BITS-1:0]         tx_word,
   output logic                        tx_take,
   input  logic                        room_idle,
   input  logic                        room_chain,
   output logic                        rx_put,
   output logic [MAX_BITS-1:0]         rx_word,
   output logic                        sclk,
   output logic                        mosi,
   input  logic                        miso,
   output logic                        busy
);
   localparam int LW = $clog2(MAX_BITS);

   eng_state_t            state;
   logic                  lat_cpol, lat_cpha, lat_lb;
   logic [MAX_BITS-1:0]   sr, rsr, rsr_next;
   logic [LW-1:0]         idx, idx_dn, len_eff;
   logic                  lead, sclk_q, mosi_q, din;
   logic                  start_idle, last_edge, chain, load;

   assign len_eff    = (cfg_len_m1 < LW'(MIN_LEN_M1)) ? LW'(MIN_LEN_M1) : cfg_len_m1;
   assign idx_dn     = idx - 1'b1;
   assign din        = lat_lb ? mosi_q : miso;
   assign rsr_next   = {rsr[MAX_BITS-2:0], din};

   assign start_idle = tick && (state == ENG_IDLE) && enable && tx_valid && room_idle;
   assign last_edge  = tick && (state == ENG_RUN) && !lead && (idx == '0);
   assign chain      = last_edge && enable && tx_valid && room_chain;
   assign load       = start_idle || chain;

   assign tx_take    = load;
   assign rx_put     = last_edge;
   assign rx_word    = lat_cpha ? rsr_next : rsr;

   assign busy       = (state == ENG_RUN);
   assign sclk       = busy ? sclk_q : cfg_cpol;
   assign mosi       = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         lat_cpol <= 1'b0;
         lat_cpha <= 1'b0;
         lat_lb   <= 1'b0;
         sr       <= '0;
         rsr      <= '0;
         idx      <= '0;
         lead     <= 1'b0;
         sclk_q   <= 1'b0;
         mosi_q   <= 1'b0;
      end else if (tick) begin
         if (load) begin
            state    <= ENG_RUN;
            lat_cpol <= cfg_cpol;
            lat_cpha <= cfg_cpha;
            lat_lb   <= cfg_loopback;
            sr       <= tx_word;
            rsr      <= '0;
            idx      <= len_eff;
            lead     <= 1'b1;
            sclk_q   <= cfg_cpol;
            if (!cfg_cpha) mosi_q <= tx_word[len_eff];
         end else if (state == ENG_RUN) begin
            if (lead) begin
               sclk_q <= ~lat_cpol;
               lead   <= 1'b0;
               if (!lat_cpha) rsr    <= rsr_next;
               else           mosi_q <= sr[idx];
            end else begin
               sclk_q <= lat_cpol;
               lead   <= 1'b1;
               if (lat_cpha) rsr <= rsr_next;
               if (idx != '0) begin
                  idx <= idx_dn;
                  if (!lat_cpha) mosi_q <= sr[idx_dn];
               end else begin
                  state <= ENG_IDLE;
               end
            end
         end
      end
   end

   // R12: the serial clock register moves only on a divider tick
   a_r12_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(sclk_q));

   // R12: the run state changes only on a divider tick
   a_r12_state_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(state));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_eng_pkg::*;
#(
   parameter int MAX_BITS   = 32,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_enable,
   input  logic                        cfg_cpol,
   input  logic                        cfg_cpha,
   input  logic                        cfg_loopback,
   input  logic [$clog2(MAX_BITS)-1:0] cfg_len_m1,
   input  logic                        tx_push,
   input  logic [MAX_BITS-1:0]         tx_wdata,
   input  logic                        rx_pop,
   output logic [MAX_BITS-1:0]         rx_rdata,
   output logic [STATUS_W-1:0]         status,
   input  logic                        sclk_tick,
   output logic                        spi_sclk,
   output logic                        spi_mosi,
   input  logic                        spi_miso,
   output logic                        spi_cs_n
);
   localparam int CW = $clog2(FIFO_DEPTH) + 1;

   generate
      if (MAX_BITS != 8 && MAX_BITS != 16 && MAX_BITS != 32) begin : g_bad_width
         $error("spi_shift_engine: MAX_BITS must be 8, 16 or 32");
      end
   endgenerate

   logic [MAX_BITS-1:0] tx_head, rx_word;
   logic [CW-1:0]       tx_level, rx_level;
   logic                tx_full, tx_empty, rx_full, rx_empty;
   logic                tx_take, rx_put, busy;
   logic                room_idle, room_chain;

   spi_eng_fifo #(.WIDTH(MAX_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_take),
      .rdata (tx_head),
      .level (tx_level),
      .full  (tx_full),
      .empty (tx_empty)
   );

   spi_eng_fifo #(.WIDTH(MAX_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_put),
      .wdata (rx_word),
      .pop   (rx_pop),
      .rdata (rx_rdata),
      .level (rx_level),
      .full  (rx_full),
      .empty (rx_empty)
   );

   // a chained start happens in the same cycle as the previous result push
   assign room_idle  = !rx_full;
   assign room_chain = (rx_level < CW'(FIFO_DEPTH - 1));

   spi_eng_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (sclk_tick),
      .enable       (cfg_enable),
      .cfg_cpol     (cfg_cpol),
      .cfg_cpha     (cfg_cpha),
      .cfg_loopback (cfg_loopback),
      .cfg_len_m1   (cfg_len_m1),
      .tx_valid     (!tx_empty),
      .tx_word      (tx_head),
      .tx_take      (tx_take),
      .room_idle    (room_idle),
      .room_chain   (room_chain),
      .rx_put       (rx_put),
      .rx_word      (rx_word),
      .sclk         (spi_sclk),
      .mosi         (spi_mosi),
      .miso         (spi_miso),
      .busy         (busy)
   );

   assign spi_cs_n = ~busy;

   always_comb begin
      status               = '0;
      status[STB_TX_EMPTY] = tx_empty;
      status[STB_TX_ROOM]  = !tx_full;
      status[STB_RX_AVAIL] = !rx_empty;
      status[STB_RX_FULL]  = rx_full;
      status[STB_BUSY]     = busy;
   end

   // R11: a result is never offered to a full receive FIFO
   a_r11_no_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_put |-> !rx_full);

   // R5: a word is only taken when the transmit FIFO holds one
   a_r5_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> !tx_empty);

   // R9: chip select only falls when the enable was high
   a_r9_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> $past(cfg_enable));

   // R7: a new select window begins only with data waiting
   a_r7_start_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> $past(!tx_empty));

endmodule

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAXB  = 32;
   localparam int DEPTH = 4;
   localparam int LW    = 5;

   typedef struct packed {
      logic        cpol;
      logic        cpha;
      logic        lb;
      logic [4:0]  lf;
      logic [1:0]  n;
      logic [31:0] t0;
      logic [31:0] t1;
      logic [31:0] m0;
      logic [31:0] m1;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 1'b0, 5'd7,  2'd1, 32'h0000_00A5, 32'h0,          32'h0000_003C, 32'h0},
      '{1'b0, 1'b1, 1'b0, 5'd7,  2'd1, 32'h0000_01C3, 32'h0,          32'h0000_005A, 32'h0},
      '{1'b1, 1'b0, 1'b0, 5'd15, 2'd2, 32'h0000_1234, 32'h0000_BEEF, 32'h0000_CAFE, 32'h0000_0F0F},
      '{1'b1, 1'b1, 1'b0, 5'd31, 2'd1, 32'hDEAD_BEEF, 32'h0,          32'h8000_0001, 32'h0},
      '{1'b0, 1'b0, 1'b1, 5'd11, 2'd2, 32'h0000_0ABC, 32'h0000_0123, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{1'b1, 1'b1, 1'b1, 5'd4,  2'd1, 32'h0000_0015, 32'h0,          32'h0,          32'h0},
      '{1'b0, 1'b1, 1'b0, 5'd1,  2'd1, 32'h0000_00F9, 32'h0,          32'h0000_0006, 32'h0},
      '{1'b1, 1'b0, 1'b0, 5'd3,  2'd2, 32'h0000_0003, 32'h0000_000C, 32'h0000_000A, 32'h0000_0005}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_enable = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_loopback = 1'b0;
   logic [LW-1:0]   cfg_len_m1 = 5'd7;
   logic            tx_push = 1'b0, rx_pop = 1'b0;
   logic [MAXB-1:0] tx_wdata = '0;
   logic [MAXB-1:0] rx_rdata;
   logic [4:0]      status;
   logic            sclk_tick = 1'b1;
   logic            spi_sclk, spi_mosi, spi_cs_n;
   logic            spi_miso = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   int cur_len;
   logic [31:0] mi_w [2];
   logic [31:0] cap_w [2];
   int          edg [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_shift_engine #(.MAX_BITS(MAXB), .FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_loopback(cfg_loopback), .cfg_len_m1(cfg_len_m1),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .status(status), .sclk_tick(sclk_tick), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int eff_len(input int f);
      return (f < 3) ? 4 : f + 1;
   endfunction

   function automatic logic [31:0] lmask(input int len);
      return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
   endfunction

   task automatic push_word(input logic [31:0] w);
      @(negedge clk);
      tx_push  = 1'b1;
      tx_wdata = w;
      @(negedge clk);
      tx_push  = 1'b0;
   endtask

   task automatic drain1(input logic [31:0] exp, input string req);
      @(negedge clk);
      check(status[2] == 1'b1, "R10 rx not empty before pop", {27'b0, status}, 32'h4);
      check(rx_rdata == exp, req, rx_rdata, exp);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   // slave model: follows SCLK edges, drives MISO, captures MOSI
   task automatic monitor(input int n);
      bit   started = 0;
      bit   fin = 0;
      int   wi = 0;
      int   bi = cur_len - 1;
      int   guard = 0;
      logic prev;
      prev = spi_sclk;
      cap_w[0] = '0; cap_w[1] = '0; edg[0] = 0; edg[1] = 0;
      while (!fin && guard < 3000) begin
         @(negedge clk);
         guard++;
         if (started) begin
            if (spi_sclk !== prev && wi < n) begin
               edg[wi]++;
               if (spi_sclk != cfg_cpol) begin
                  if (!cfg_cpha) cap_w[wi] = {cap_w[wi][30:0], spi_mosi};
                  else           spi_miso = mi_w[wi][bi];
               end else begin
                  if (cfg_cpha) cap_w[wi] = {cap_w[wi][30:0], spi_mosi};
                  bi--;
                  if (bi < 0) begin
                     wi++;
                     bi = cur_len - 1;
                  end
                  if (!cfg_cpha && wi < n) spi_miso = mi_w[wi][bi];
               end
            end
            if (spi_cs_n) fin = 1;
         end else if (!spi_cs_n) begin
            started = 1;
            check(spi_sclk == cfg_cpol, "R3 sclk at idle level at select", {31'b0, spi_sclk}, {31'b0, cfg_cpol});
            check(spi_sclk === prev, "R7 select before first edge", {31'b0, spi_sclk}, {31'b0, prev});
            check(status[4] == 1'b1, "R8 busy while selected", {27'b0, status}, 32'h10);
            if (!cfg_cpha) spi_miso = mi_w[0][cur_len-1];
         end
         prev = spi_sclk;
      end
      check(fin == 1'b1, "R7 select released", {31'b0, fin}, 32'h1);
      check(wi == n, "R7 all words in one select window", wi, n);
      check(status[4] == 1'b0, "R8 busy low after release", {27'b0, status}, 32'h0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(spi_cs_n == 1'b1, "R1 select inactive after reset", {31'b0, spi_cs_n}, 32'h1);
      check(status == 5'b00011, "R1 R10 status after reset", {27'b0, status}, 32'h3);
      check(spi_sclk == 1'b0, "R3 idle sclk low for cpol 0", {31'b0, spi_sclk}, 32'h0);
      cfg_cpol = 1'b1;
      @(negedge clk);
      check(spi_sclk == 1'b1, "R3 idle sclk follows cpol 1", {31'b0, spi_sclk}, 32'h1);

      // table walk
      for (int v = 0; v < 8; v++) begin
         vec_t        t;
         logic [31:0] txw [2];
         t = VECS[v];
         cfg_enable   = 1'b0;
         cfg_cpol     = t.cpol;
         cfg_cpha     = t.cpha;
         cfg_loopback = t.lb;
         cfg_len_m1   = t.lf;
         cur_len      = eff_len(int'(t.lf));
         txw[0] = t.t0; txw[1] = t.t1;
         mi_w[0] = t.m0; mi_w[1] = t.m1;
         for (int w = 0; w < int'(t.n); w++) push_word(txw[w]);
         cfg_enable = 1'b1;
         monitor(int'(t.n));
         cfg_enable = 1'b0;
         for (int w = 0; w < int'(t.n); w++) begin
            logic [31:0] m;
            m = lmask(cur_len);
            check(cap_w[w] == (txw[w] & m), "R2 mosi bits msb first", cap_w[w], txw[w] & m);
            check(edg[w] == 2 * cur_len, "R4 edge count per word", edg[w], 2 * cur_len);
         end
         for (int w = 0; w < int'(t.n); w++) begin
            logic [31:0] m;
            m = lmask(cur_len);
            if (t.lb) drain1(txw[w] & m, "R6 loopback result");
            else      drain1(mi_w[w] & m, "R5 R4 received word");
         end
         @(negedge clk);
         check(status[2] == 1'b0, "R5 one result per word", {27'b0, status}, 32'h0);
      end

      // R12: nothing moves without ticks
      cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_loopback = 1'b1; cfg_len_m1 = 5'd7; cur_len = 8;
      sclk_tick = 1'b0;
      push_word(32'h5A);
      cfg_enable = 1'b1;
      repeat (10) @(negedge clk);
      check(spi_cs_n == 1'b1, "R12 no start without tick", {31'b0, spi_cs_n}, 32'h1);
      check(status[0] == 1'b0, "R10 tx not empty flag", {27'b0, status}, 32'h0);
      sclk_tick = 1'b1;
      monitor(1);
      drain1(32'h5A, "R12 word after ticks resume");
      cfg_enable = 1'b0;

      // R9: enable low holds start; drop mid-word
      push_word(32'h11);
      push_word(32'h22);
      repeat (5) @(negedge clk);
      check(spi_cs_n == 1'b1, "R9 no start while disabled", {31'b0, spi_cs_n}, 32'h1);
      cfg_enable = 1'b1;
      for (int i = 0; i < 20 && spi_cs_n; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      cfg_enable = 1'b0;
      for (int i = 0; i < 100 && !spi_cs_n; i++) @(negedge clk);
      repeat (5) @(negedge clk);
      check(spi_cs_n == 1'b1, "R9 released after current word", {31'b0, spi_cs_n}, 32'h1);
      check(status[0] == 1'b0, "R9 second word still queued", {27'b0, status}, 32'h0);
      drain1(32'h11, "R9 in-flight word completed");
      @(negedge clk);
      check(status[2] == 1'b0, "R9 only one result", {27'b0, status}, 32'h0);
      cfg_enable = 1'b1;
      monitor(1);
      cfg_enable = 1'b0;
      drain1(32'h22, "R9 queued word after re-enable");

      // R11: receive FIFO full blocks the next word
      cfg_len_m1 = 5'd3; cur_len = 4;
      for (int i = 1; i <= 4; i++) push_word(32'(i));
      cfg_enable = 1'b1;
      repeat (60) @(negedge clk);
      check(status[3] == 1'b1, "R10 rx full flag", {27'b0, status}, 32'h8);
      check(status[0] == 1'b1, "R10 tx empty flag", {27'b0, status}, 32'h1);
      push_word(32'hF5);
      repeat (20) @(negedge clk);
      check(spi_cs_n == 1'b1, "R11 held while rx full", {31'b0, spi_cs_n}, 32'h1);
      check(status[0] == 1'b0, "R11 word waits in tx fifo", {27'b0, status}, 32'h0);
      for (int i = 1; i <= 4; i++) drain1(32'(i), "R11 results in order");
      repeat (20) @(negedge clk);
      drain1(32'h5, "R11 blocked word sent after pop");
      cfg_enable = 1'b0;

      // R11: push to full tx fifo dropped, pop on empty harmless
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      check(status == 5'b00011, "R11 pop on empty no effect", {27'b0, status}, 32'h3);
      for (int i = 10; i <= 14; i++) push_word(32'(i));
      check(status[1] == 1'b0, "R10 tx full flag", {27'b0, status}, 32'h0);
      cfg_enable = 1'b1;
      repeat (60) @(negedge clk);
      cfg_enable = 1'b0;
      for (int i = 10; i <= 13; i++) drain1(32'(i), "R11 first four words kept");
      @(negedge clk);
      check(status == 5'b00011, "R11 extra push dropped", {27'b0, status}, 32'h3);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule